// File: doc/BRIEF.md
# Fractional time-of-day counter

This block keeps a precision wall-clock time made of a 48-bit seconds count and a 30-bit nanoseconds count, plus a hidden 59-bit fraction of a nanosecond. On every clock edge where counting is enabled, it adds a programmable increment to the nanoseconds and fraction. The increment is a 64-bit fixed-point value with 5 integer bits and 59 fractional bits. When the nanoseconds reach one second they wrap, and the seconds count advances on the same edge.

Software reaches the block through a small word-wide register port. Three time words form one shared access channel. Writing an action code acts on that channel. LOAD copies the channel into the counter. SAVE copies the live counter into the channel. DELTA adds a signed nanosecond correction to the running time.

The increment can be retuned at run time for frequency trimming. Its two 32-bit halves are written into a shadow, with a gate bit set in the control word. The running counter switches to the new value only when the gate bit is cleared, so it never uses a half-written increment. A small negative correction near the top of a second leaves the nanoseconds field in a short borrow window instead of taking a second away. Software reading that window interprets it as one second less.

Top module: `frac_tod_clock`

## Requirements
- R1: After reset the time is zero (seconds 0, nanoseconds 0) and the control word reads 0. The increment halves read back the nominal value 0x304d4873_ecade305: address 1 returns the low word and address 2 returns the high word.
- R2: Control word at address 0: bit 0 enables counting and bit 1 is the increment gate. While bit 0 is clear, the time does not change except through an action. A write of bit 0 first affects the edge after the write edge.
- R3: On each enabled edge, {nanoseconds, fraction} grows by the active increment. When the fraction starts at zero, j enabled edges after time t0 the time is t0 + floor(j * inc / 2^59) ns.
- R4: When nanoseconds plus the increment reach 1,000,000,000, nanoseconds wrap to the remainder and seconds increase by one on that same edge. The carry passes from the low 32 bits of seconds into the upper 16 bits, and the fraction is kept.
- R5: Writes to the increment halves only fill a shadow. The active increment is replaced only by a control write that clears bit 1 while it was set. The edge of that write still uses the old increment, and the new one is used from the next edge on. Any other increment write has no effect on the counting rate.
- R6: Writing code 1 (LOAD) to the action register (address 3, bits [2:0]) copies the channel into the counter on the write edge and clears the fraction. The channel is seconds-high at address 4 bits [15:0], seconds-low at address 5, and nanoseconds at address 6 bits [29:0]. No increment is added on that edge.
- R7: Writing code 2 (SAVE) copies the live seconds and nanoseconds, as they stood just before the write edge, into the channel as one coherent snapshot readable at addresses 4, 5 and 6.
- R8: Writing code 4 (DELTA) adds the nanoseconds channel word, read as a signed 30-bit value, to the time on the write edge, together with that edge's increment. A sum of 1,000,000,000 or more gives seconds + 1 and sum - 10^9. A sum below -16 gives seconds - 1 and sum + 10^9.
- R9: A DELTA sum s in -16..-1 leaves seconds unchanged and stores 2^30 + s (0x3FFFFFF0..0x3FFFFFFF). Counting from that window continues modulo 2^30 into small positive values without changing the seconds.
- R10: Action codes 0 (IDLE), 3, 5, 6 and 7 change neither the time nor the channel words. The action register reads back the last code written.
- R11: The nanoseconds field always holds either a value below 1,000,000,000 or a value in the borrow window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| tod_sec | output | 48 | Live seconds count |
| tod_nsec | output | 30 | Live nanoseconds count |

## Verification
LOAD, SAVE and DELTA take effect on the rising edge that samples their action write. A change of the enable bit first counts one edge later, and a committed increment is first used one edge after the gate-clearing write. The bench drives every write at a falling edge and samples the live time and the read port at the next falling edge. That makes each expected value a function of a known number of increments: zero for actions taken while disabled, one for the write edge while running. Counting sweeps compare every sampled cycle against start + floor(j*inc/2^59), computed with wide arithmetic in the bench. The correction cases derive seconds and nanoseconds from the rollover and borrow rules.

// File: rtl/frac_tod_pkg.sv
package frac_tod_pkg;

   typedef enum logic [2:0] {
      ACT_IDLE  = 3'd0,
      ACT_LOAD  = 3'd1,
      ACT_SAVE  = 3'd2,
      ACT_CLOCK = 3'd3,
      ACT_DELTA = 3'd4,
      ACT_TOD   = 3'd5
   } tod_act_e;

   localparam logic [2:0] RA_CTRL   = 3'd0;
   localparam logic [2:0] RA_INC_LO = 3'd1;
   localparam logic [2:0] RA_INC_HI = 3'd2;
   localparam logic [2:0] RA_ACTION = 3'd3;
   localparam logic [2:0] RA_SEC_HI = 3'd4;
   localparam logic [2:0] RA_SEC_LO = 3'd5;
   localparam logic [2:0] RA_NSEC   = 3'd6;

endpackage

// File: rtl/tod_inc_cfg.sv
module tod_inc_cfg #(
   parameter int              DATA_W  = 32,
   parameter int              INC_W   = 64,
   parameter logic [INC_W-1:0] NOMINAL = 64'h304d4873ecade305
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [INC_W/DATA_W-1:0]   half_we,
   input  logic [DATA_W-1:0]         wdata,
   input  logic                      commit,
   output logic [INC_W-1:0]          shadow,
   output logic [INC_W-1:0]          active
);
   localparam int HALVES = INC_W / DATA_W;

   logic [DATA_W-1:0] half_q [HALVES];

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          half_q[h] <= NOMINAL[h*DATA_W +: DATA_W];
         else if (half_we[h]) half_q[h] <= wdata;
      end
      assign shadow[h*DATA_W +: DATA_W] = half_q[h];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active <= NOMINAL;
      else if (commit) active <= shadow;
   end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
   parameter int          SEC_W       = 48,
   parameter int          NS_W        = 30,
   parameter int          INC_INT_W   = 5,
   parameter int          FRAC_W      = 59,
   parameter int unsigned NS_PER_SEC  = 1000000000,
   parameter int          BORROW_SPAN = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick_en,
   input  logic [INC_INT_W+FRAC_W-1:0]   inc,
   input  logic                          load,
   input  logic [SEC_W-1:0]              load_sec,
   input  logic [NS_W-1:0]               load_ns,
   input  logic                          delta_en,
   input  logic [NS_W-1:0]               delta_ns,
   output logic [SEC_W-1:0]              sec_q,
   output logic [NS_W-1:0]               ns_q
);
   localparam int INC_W = INC_INT_W + FRAC_W;
   localparam int SW    = NS_W + 3;
   localparam longint unsigned WIN_L = (64'd1 << NS_W) - 64'(BORROW_SPAN);
   localparam logic [NS_W-1:0] WIN_NS = NS_W'(WIN_L);
   localparam logic signed [SW-1:0] LIM_HI = SW'(NS_PER_SEC);
   localparam logic signed [SW-1:0] LIM_LO = -$signed(SW'(BORROW_SPAN));

   logic [FRAC_W-1:0]      frac_q, frac_nx;
   logic [FRAC_W:0]        frac_sum;
   logic                   in_win;
   logic signed [SW-1:0]   ns_val, step, dlt, s;
   logic [SEC_W-1:0]       sec_nx;
   logic [NS_W-1:0]        ns_nx;

   always_comb begin
      in_win   = ns_q >= WIN_NS;
      ns_val   = $signed({{3{in_win}}, ns_q});
      frac_sum = {1'b0, frac_q} + {1'b0, inc[FRAC_W-1:0]};
      step     = tick_en ? $signed(SW'(inc[INC_W-1:FRAC_W]) + SW'(frac_sum[FRAC_W])) : '0;
      dlt      = delta_en ? SW'($signed(delta_ns)) : '0;
      s        = ns_val + step + dlt;
      frac_nx  = tick_en ? frac_sum[FRAC_W-1:0] : frac_q;
      sec_nx   = sec_q;
      if (s >= LIM_HI) begin
         ns_nx  = NS_W'(s - LIM_HI);
         sec_nx = sec_q + 1'b1;
      end else if (s < LIM_LO) begin
         ns_nx  = NS_W'(s + LIM_HI);
         sec_nx = sec_q - 1'b1;
      end else begin
         ns_nx  = s[NS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         ns_q   <= '0;
         frac_q <= '0;
      end else if (load) begin
         sec_q  <= load_sec;
         ns_q   <= load_ns;
         frac_q <= '0;
      end else begin
         sec_q  <= sec_nx;
         ns_q   <= ns_nx;
         frac_q <= frac_nx;
      end
   end
endmodule

// File: rtl/tod_access.sv
module tod_access #(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 48,
   parameter int NS_W   = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_hi,
   input  logic               we_lo,
   input  logic               we_ns,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               save,
   input  logic [SEC_W-1:0]   live_sec,
   input  logic [NS_W-1:0]    live_ns,
   output logic [SEC_W-1:0]   acc_sec,
   output logic [NS_W-1:0]    acc_ns
);
   localparam int HI_W = SEC_W - DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_sec <= '0;
         acc_ns  <= '0;
      end else if (save) begin
         acc_sec <= live_sec;
         acc_ns  <= live_ns;
      end else begin
         if (we_hi) acc_sec[SEC_W-1:DATA_W] <= wdata[HI_W-1:0];
         if (we_lo) acc_sec[DATA_W-1:0]     <= wdata;
         if (we_ns) acc_ns                  <= wdata[NS_W-1:0];
      end
   end
endmodule

// File: rtl/frac_tod_clock.sv
module frac_tod_clock
   import frac_tod_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 3,
   parameter int          SEC_W       = 48,
   parameter int          NS_W        = 30,
   parameter int          INC_INT_W   = 5,
   parameter int          FRAC_W      = 59,
   parameter int unsigned NS_PER_SEC  = 1000000000,
   parameter int          BORROW_SPAN = 16,
   parameter logic [INC_INT_W+FRAC_W-1:0] NOMINAL_INC = 64'h304d4873ecade305
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_nsec
);
   localparam int INC_W  = INC_INT_W + FRAC_W;
   localparam int HALVES = INC_W / DATA_W;

   if (INC_W != 2 * DATA_W) begin : g_bad_inc
      $error("increment width must equal two data words");
   end
   if (SEC_W <= DATA_W || SEC_W > 2 * DATA_W) begin : g_bad_sec
      $error("seconds width must span more than one and at most two data words");
   end
   if (NS_W >= DATA_W || (64'd1 << NS_W) <= 64'(NS_PER_SEC) + 64'(BORROW_SPAN)) begin : g_bad_ns
      $error("nanosecond field cannot hold a second plus the borrow window");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("address must be at least three bits");
   end

   logic              enable_q, gate_q;
   logic [2:0]        act_q;
   logic              we_ctrl, we_act, commit;
   logic              do_load, do_save, do_delta, act_any;
   logic [HALVES-1:0] half_we;
   logic [INC_W-1:0]  inc_shadow, inc_active;
   logic [SEC_W-1:0]  acc_sec;
   logic [NS_W-1:0]   acc_ns;

   always_comb begin
      we_ctrl    = wr_en && wr_addr == ADDR_W'(RA_CTRL);
      we_act     = wr_en && wr_addr == ADDR_W'(RA_ACTION);
      half_we[0] = wr_en && wr_addr == ADDR_W'(RA_INC_LO);
      half_we[1] = wr_en && wr_addr == ADDR_W'(RA_INC_HI);
      commit     = we_ctrl && gate_q && !wr_data[1];
      do_load    = we_act && wr_data[2:0] == ACT_LOAD;
      do_save    = we_act && wr_data[2:0] == ACT_SAVE;
      do_delta   = we_act && wr_data[2:0] == ACT_DELTA;
      act_any    = do_load || do_save || do_delta;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         gate_q   <= 1'b0;
         act_q    <= ACT_IDLE;
      end else begin
         if (we_ctrl) begin
            enable_q <= wr_data[0];
            gate_q   <= wr_data[1];
         end
         if (we_act) act_q <= wr_data[2:0];
      end
   end

   tod_inc_cfg #(.DATA_W(DATA_W), .INC_W(INC_W), .NOMINAL(NOMINAL_INC)) u_inc (
      .clk(clk), .rst_n(rst_n), .half_we(half_we), .wdata(wr_data),
      .commit(commit), .shadow(inc_shadow), .active(inc_active));

   tod_access #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .we_hi(wr_en && wr_addr == ADDR_W'(RA_SEC_HI)),
      .we_lo(wr_en && wr_addr == ADDR_W'(RA_SEC_LO)),
      .we_ns(wr_en && wr_addr == ADDR_W'(RA_NSEC)),
      .wdata(wr_data), .save(do_save), .live_sec(tod_sec), .live_ns(tod_nsec),
      .acc_sec(acc_sec), .acc_ns(acc_ns));

   tod_accum #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_INT_W(INC_INT_W), .FRAC_W(FRAC_W),
               .NS_PER_SEC(NS_PER_SEC), .BORROW_SPAN(BORROW_SPAN)) u_accum (
      .clk(clk), .rst_n(rst_n), .tick_en(enable_q), .inc(inc_active),
      .load(do_load), .load_sec(acc_sec), .load_ns(acc_ns),
      .delta_en(do_delta), .delta_ns(acc_ns),
      .sec_q(tod_sec), .ns_q(tod_nsec));

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(RA_CTRL):   rd_data[1:0] = {gate_q, enable_q};
         ADDR_W'(RA_INC_LO): rd_data = inc_shadow[DATA_W-1:0];
         ADDR_W'(RA_INC_HI): rd_data = inc_shadow[INC_W-1:DATA_W];
         ADDR_W'(RA_ACTION): rd_data[2:0] = act_q;
         ADDR_W'(RA_SEC_HI): rd_data = DATA_W'(acc_sec[SEC_W-1:DATA_W]);
         ADDR_W'(RA_SEC_LO): rd_data = acc_sec[DATA_W-1:0];
         ADDR_W'(RA_NSEC):   rd_data = DATA_W'(acc_ns);
         default:            rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tod_chk.sv
module tod_chk #(
   parameter int          SEC_W       = 48,
   parameter int          NS_W        = 30,
   parameter int          INC_W       = 64,
   parameter int unsigned NS_PER_SEC  = 1000000000,
   parameter int          BORROW_SPAN = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             load,
   input logic             save,
   input logic             act_any,
   input logic             commit,
   input logic [INC_W-1:0] inc_active,
   input logic [SEC_W-1:0] sec,
   input logic [NS_W-1:0]  ns,
   input logic [SEC_W-1:0] acc_sec,
   input logic [NS_W-1:0]  acc_ns
);
   localparam longint unsigned WIN_L = (64'd1 << NS_W) - 64'(BORROW_SPAN);

   // R11
   ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (64'(ns) < 64'(NS_PER_SEC)) || (64'(ns) >= WIN_L));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !act_any) |=> ($stable(sec) && $stable(ns)));

   // R5
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(inc_active));

   // R6
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sec == $past(acc_sec) && ns == $past(acc_ns)));

   // R7
   save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save |=> (acc_sec == $past(sec) && acc_ns == $past(ns)));

   // R4
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (sec == $past(sec) || sec == $past(sec) + 1'b1 || sec == $past(sec) - 1'b1));
endmodule

bind frac_tod_clock tod_chk #(
   .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W),
   .NS_PER_SEC(NS_PER_SEC), .BORROW_SPAN(BORROW_SPAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable_q), .load(do_load), .save(do_save),
   .act_any(act_any), .commit(commit), .inc_active(inc_active),
   .sec(tod_sec), .ns(tod_nsec), .acc_sec(acc_sec), .acc_ns(acc_ns));

// File: tb/frac_tod_clock_test.sv
module frac_tod_clock_test;
   localparam logic [63:0] NOM   = 64'h304d4873ecade305;
   localparam logic [63:0] INC8  = 64'h4000000000000000;
   localparam logic [63:0] INC15 = 64'h0C00000000000000;
   localparam longint      BIL   = 1000000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [47:0] tod_sec;
   logic [29:0] tod_nsec;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   frac_tod_clock uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_nsec(tod_nsec));

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic chk_time(input logic [47:0] es, input logic [29:0] en, input string req);
      check(tod_sec == es, req, 64'(tod_sec), 64'(es));
      check(tod_nsec == en, req, 64'(tod_nsec), 64'(en));
   endtask

   function automatic longint adv(input logic [63:0] inc, input int j);
      logic [127:0] p;
      p = 128'(inc) * 128'(j);
      return longint'(p >> 59);
   endfunction

   task automatic load_time(input logic [47:0] s, input logic [29:0] n);
      wr(3'd3, 32'd0);
      wr(3'd4, 32'(s[47:32]));
      wr(3'd5, s[31:0]);
      wr(3'd6, 32'(n));
      wr(3'd3, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [47:0] ssnap;
      logic [29:0] nsnap, nbase;
      longint tot, s;
      longint st [10] = '{500, 999999990, 10, 10, 10, 10, 0, 600000000, 999999999, 5};
      longint dl [10] = '{1000, 20, -20, -100, -26, -27, -499999999, 499999999, 1, -5};
      int codes [5] = '{0, 3, 5, 6, 7};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_time(48'd0, 30'd0, "R1");
      rd(3'd0, d); check(d == 0, "R1 ctrl", 64'(d), 0);
      rd(3'd1, d); check(d == NOM[31:0], "R1 inc_lo", 64'(d), 64'(NOM[31:0]));
      rd(3'd2, d); check(d == NOM[63:32], "R1 inc_hi", 64'(d), 64'(NOM[63:32]));
      repeat (5) @(negedge clk);
      chk_time(48'd0, 30'd0, "R2 hold while disabled");

      // R6 load, then R3 sweep at nominal rate
      load_time(48'h00123456789A, 30'd100);
      chk_time(48'h00123456789A, 30'd100, "R6 load");
      rd(3'd5, d); check(d == 32'h3456789A, "R6 sec_lo readback", 64'(d), 64'h3456789A);
      wr(3'd0, 32'd1);
      chk_time(48'h00123456789A, 30'd100, "R2 enable latency");
      for (int j = 1; j <= 48; j++) begin
         @(negedge clk);
         chk_time(48'h00123456789A, 30'(100 + adv(NOM, j)), "R3 nominal sweep");
      end
      wr(3'd0, 32'd0);

      // R4 rollover across the seconds words
      load_time(48'h0001FFFFFFFF, 30'd999999950);
      wr(3'd0, 32'd1);
      for (int j = 1; j <= 20; j++) begin
         @(negedge clk);
         tot = 999999950 + adv(NOM, j);
         if (tot >= BIL) chk_time(48'h000200000000, 30'(tot - BIL), "R4 rollover");
         else            chk_time(48'h0001FFFFFFFF, 30'(tot), "R4 before rollover");
      end

      // R7 snapshot while running
      repeat (3) @(negedge clk);
      ssnap = tod_sec; nsnap = tod_nsec;
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd2;
      @(negedge clk);
      wr_en = 1'b0;
      rd(3'd4, d); check(d == 32'(ssnap[47:32]), "R7 sec_hi", 64'(d), 64'(ssnap[47:32]));
      rd(3'd5, d); check(d == ssnap[31:0], "R7 sec_lo", 64'(d), 64'(ssnap[31:0]));
      rd(3'd6, d); check(d == 32'(nsnap), "R7 nsec", 64'(d), 64'(nsnap));
      wr(3'd0, 32'd0);

      // R8 / R9 correction sweep while disabled
      for (int i = 0; i < 10; i++) begin
         load_time(48'd5, 30'(st[i]));
         wr(3'd6, 32'(dl[i]) & 32'h3FFFFFFF);
         wr(3'd3, 32'd4);
         s = st[i] + dl[i];
         if (s >= BIL)     chk_time(48'd6, 30'(s - BIL), "R8 forward carry");
         else if (s < -16) chk_time(48'd4, 30'(s + BIL), "R8 backward borrow");
         else if (s < 0)   chk_time(48'd5, 30'((longint'(1) << 30) + s), "R9 borrow window");
         else              chk_time(48'd5, 30'(s), "R8 in range");
      end

      // R10 inert action codes
      load_time(48'd7, 30'd1234);
      wr(3'd4, 32'h0000AAAA);
      wr(3'd5, 32'h00000055);
      wr(3'd6, 32'd777);
      for (int i = 0; i < 5; i++) begin
         wr(3'd3, 32'(codes[i]));
         chk_time(48'd7, 30'd1234, "R10 time untouched");
         rd(3'd6, d); check(d == 777, "R10 nsec channel", 64'(d), 777);
         rd(3'd5, d); check(d == 32'h55, "R10 sec_lo channel", 64'(d), 64'h55);
         rd(3'd3, d); check(d == 32'(codes[i]), "R10 action readback", 64'(d), 64'(codes[i]));
      end

      // R5 commit an 8 ns increment, R9 count out of the window
      wr(3'd0, 32'd2);
      wr(3'd1, 32'd0);
      wr(3'd2, INC8[63:32]);
      wr(3'd0, 32'd0);
      load_time(48'd5, 30'd10);
      wr(3'd6, 32'h3FFFFFEC);
      wr(3'd3, 32'd4);
      chk_time(48'd5, 30'h3FFFFFF6, "R9 enter window");
      wr(3'd0, 32'd1);
      @(negedge clk); chk_time(48'd5, 30'h3FFFFFFE, "R9 count in window");
      @(negedge clk); chk_time(48'd5, 30'd6, "R9 leave window");
      @(negedge clk); chk_time(48'd5, 30'd14, "R5 new rate");

      // R8 correction while running adds the edge increment
      wr(3'd6, 32'd1000);
      @(negedge clk);
      nbase = tod_nsec; ssnap = tod_sec;
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd4;
      @(negedge clk);
      wr_en = 1'b0;
      chk_time(ssnap, nbase + 30'd1008, "R8 delta while running");

      // R6 load while running: no increment on the load edge
      wr(3'd4, 32'd0);
      wr(3'd5, 32'd9);
      wr(3'd6, 32'd50);
      wr(3'd3, 32'd1);
      chk_time(48'd9, 30'd50, "R6 load while running");
      @(negedge clk); chk_time(48'd9, 30'd58, "R3 after load");

      // R5 ungated write and gated write leave the rate alone
      wr(3'd2, INC15[63:32]);
      nbase = tod_nsec;
      @(negedge clk); check(tod_nsec == nbase + 30'd8, "R5 ungated write ignored", 64'(tod_nsec), 64'(nbase + 30'd8));
      rd(3'd2, d); check(d == INC15[63:32], "R5 shadow readback", 64'(d), 64'(INC15[63:32]));
      wr(3'd0, 32'd3);
      nbase = tod_nsec;
      @(negedge clk); check(tod_nsec == nbase + 30'd8, "R5 gated hold", 64'(tod_nsec), 64'(nbase + 30'd8));
      nbase = tod_nsec;
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd1;
      @(negedge clk);
      wr_en = 1'b0;
      check(tod_nsec == nbase + 30'd8, "R5 commit edge uses old", 64'(tod_nsec), 64'(nbase + 30'd8));
      nbase = tod_nsec;
      for (int j = 1; j <= 8; j++) begin
         @(negedge clk);
         check(tod_nsec == nbase + 30'(adv(INC15, j)), "R5 committed rate",
               64'(tod_nsec), 64'(nbase + 30'(adv(INC15, j))));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule